// File: doc/BRIEF.md
# Framebuffer Display Window Timing Generator

This block produces the raster timing for a display panel and places a rectangular framebuffer image inside that raster. A horizontal counter steps on every pixel clock. A vertical counter steps once per line. Each counter runs over a programmable total span, and that span includes the blank lead-in before the image. Horizontal and vertical sync pulses of programmable length begin at the start of each line and at the start of each frame.

The visible image is a window. Its position is set by an X and Y offset and its size by a width and a height, all inside the total span. A typical setup is a 950 by 488 raster with an 854 by 480 window at (96, 8). The same raster can also hold a 640-pixel-wide window, and a wider 1056-clock line can carry the window at X offset 202. For each pixel inside the window the block raises a fetch request and gives the byte address of that pixel in a 22-bit memory space. The address is formed from a start address, a row stride in bytes and the pixel size. The stride does not depend on the window width.

All settings are copied into shadow registers during reset and at each frame boundary. A frame in progress therefore never sees a mix of old and new settings. The memory interface and the pixel decoding are left to neighbouring blocks.

Top module: `fb_window_timing`

## Requirements
- R1: `h_cnt` is 0 in the first cycle after reset, rises by one on every clock, and returns to 0 after reaching horizontal total minus one.
- R2: `v_cnt` is 0 after reset. It rises by one only in the cycle where `h_cnt` wraps, and it returns to 0 when it wraps from vertical total minus one.
- R3: `hsync` is high exactly while `h_cnt` is below the horizontal sync length. `vsync` is high exactly while `v_cnt` is below the vertical sync length.
- R4: `win_active` is high exactly when X offset <= `h_cnt` < X offset + width and Y offset <= `v_cnt` < Y offset + height.
- R5: `fetch_req` equals `win_active`. While the window is inactive, `fetch_addr` is 0.
- R6: Inside the window, `fetch_addr` = (start + (`v_cnt` - Y offset) * stride + P) modulo 2^22. Here c = `h_cnt` - X offset and P depends on `cfg_fmt`: code 0 gives P = c (one byte per pixel), code 1 gives P = floor(c/2) (4-bit pixels), and codes 2 and 3 give P = 2c (16-bit pixels).
- R7: The first pixels of two consecutive window rows have addresses exactly one stride apart. This holds whether the stride is larger or smaller than width times bytes per pixel.
- R8: Every `cfg_*` input is captured only while reset is held and in the cycle where both counters wrap. A change made mid-frame has no effect on any output until the counters return to (0,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset; captures the configuration |
| cfg_h_total | input | 12 | Clocks per line, including X offset |
| cfg_v_total | input | 12 | Lines per frame, including Y offset |
| cfg_hsync_len | input | 12 | Horizontal sync pulse length in clocks |
| cfg_vsync_len | input | 12 | Vertical sync pulse length in lines |
| cfg_x_off | input | 12 | First window column |
| cfg_width | input | 12 | Window width in pixels |
| cfg_y_off | input | 12 | First window line |
| cfg_height | input | 12 | Window height in lines |
| cfg_stride | input | 16 | Bytes between the starts of consecutive rows |
| cfg_base | input | 22 | Byte address of the window's first pixel |
| cfg_fmt | input | 2 | Pixel size code (0 byte, 1 nibble, 2/3 two bytes) |
| h_cnt | output | 12 | Horizontal position |
| v_cnt | output | 12 | Vertical position |
| hsync | output | 1 | Line sync pulse |
| vsync | output | 1 | Frame sync pulse |
| win_active | output | 1 | Position lies inside the window |
| fetch_req | output | 1 | Fetch the pixel at `fetch_addr` |
| fetch_addr | output | 22 | Byte address of the current pixel |

## Verification
The assertions assume a sane configuration. Each total must be at least 2. Each sync length must not exceed its total. The window must lie within the span, so offset plus size is at most the total. The start address and stride must fit their ports. The stimulus loads only settings that meet these conditions. It changes them only at falling clock edges, and sometimes in the middle of a frame, so that the frame-boundary capture is exercised. The raster sizes used are short enough that several full frames finish within the run. The full-size raster modes are checked over their first dozen lines.

// File: rtl/fbw_pkg.sv
package fbw_pkg;

  typedef enum logic [1:0] {
    PIX_BYTE   = 2'd0,
    PIX_NIBBLE = 2'd1,
    PIX_HALF16 = 2'd2,
    PIX_WORD16 = 2'd3
  } pix_fmt_e;

  // Position lies in [off, off+len)
  function automatic logic in_span(input logic [31:0] pos,
                                   input logic [31:0] off,
                                   input logic [31:0] len);
    return (pos >= off) && (pos < off + len);
  endfunction

  // Byte offset of a pixel column inside its row
  function automatic logic [31:0] pix_offset(input logic [31:0] col,
                                             input pix_fmt_e fmt);
    logic [31:0] r;
    case (fmt)
      PIX_BYTE:   r = col;
      PIX_NIBBLE: r = col >> 1;
      default:    r = col << 1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fbw_axis.sv
module fbw_axis #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [CNT_W-1:0] total,
  input  logic [CNT_W-1:0] sync_len,
  input  logic [CNT_W-1:0] win_off,
  input  logic [CNT_W-1:0] win_len,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap,
  output logic             sync,
  output logic             in_win
);

  logic [CNT_W-1:0] cnt_q;
  logic             at_last;

  assign at_last = (cnt_q == total - CNT_W'(1));
  assign wrap    = step & at_last;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (step)   cnt_q <= at_last ? '0 : cnt_q + CNT_W'(1);
  end

  assign cnt    = cnt_q;
  assign sync   = (cnt_q < sync_len);
  assign in_win = fbw_pkg::in_span(32'(cnt_q), 32'(win_off), 32'(win_len));

  // R1 for the horizontal instance, R2 for the vertical one
  assert_cnt_below_total_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < total);

  assert_wrap_to_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt_q == '0);

  assert_step_incr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !at_last) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  assert_hold_no_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt_q));

  assert_sync_starts_at_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync) |-> cnt_q == '0);

endmodule

// File: rtl/fbw_addr_gen.sv
module fbw_addr_gen #(
  parameter int ADDR_W   = 22,
  parameter int CNT_W    = 12,
  parameter int STRIDE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_end,
  input  logic                line_end,
  input  logic                row_in_win,
  input  logic                active,
  input  logic [ADDR_W-1:0]   base_in,
  input  logic [STRIDE_W-1:0] stride,
  input  logic [CNT_W-1:0]    col,
  input  fbw_pkg::pix_fmt_e   fmt,
  output logic [ADDR_W-1:0]   addr
);

  logic [ADDR_W-1:0] row_base;
  logic [ADDR_W-1:0] col_bytes;
  logic              row_advance;

  assign row_advance = line_end & row_in_win & ~frame_end;

  // Row start accumulates the stride once per window line: one adder, no multiplier
  always_ff @(posedge clk) begin
    if (!rst_n)           row_base <= base_in;
    else if (frame_end)   row_base <= base_in;
    else if (row_advance) row_base <= row_base + ADDR_W'(stride);
  end

  assign col_bytes = ADDR_W'(fbw_pkg::pix_offset(32'(col), fmt));
  assign addr      = active ? (row_base + col_bytes) : '0;

  assert_row_base_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> row_base == $past(base_in));

  assert_row_hold_outside_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && !row_in_win && !frame_end) |=> $stable(row_base));

endmodule

// File: rtl/fb_window_timing.sv
module fb_window_timing #(
  parameter int CNT_W    = 12,
  parameter int STRIDE_W = 16,
  parameter int ADDR_W   = 22
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CNT_W-1:0]    cfg_h_total,
  input  logic [CNT_W-1:0]    cfg_v_total,
  input  logic [CNT_W-1:0]    cfg_hsync_len,
  input  logic [CNT_W-1:0]    cfg_vsync_len,
  input  logic [CNT_W-1:0]    cfg_x_off,
  input  logic [CNT_W-1:0]    cfg_width,
  input  logic [CNT_W-1:0]    cfg_y_off,
  input  logic [CNT_W-1:0]    cfg_height,
  input  logic [STRIDE_W-1:0] cfg_stride,
  input  logic [ADDR_W-1:0]   cfg_base,
  input  logic [1:0]          cfg_fmt,
  output logic [CNT_W-1:0]    h_cnt,
  output logic [CNT_W-1:0]    v_cnt,
  output logic                hsync,
  output logic                vsync,
  output logic                win_active,
  output logic                fetch_req,
  output logic [ADDR_W-1:0]   fetch_addr
);

  import fbw_pkg::*;

  // Shadow copies, reloaded in reset and at frame boundaries only
  logic [CNT_W-1:0]    s_h_total, s_v_total, s_hsync, s_vsync;
  logic [CNT_W-1:0]    s_x_off, s_width, s_y_off, s_height;
  logic [STRIDE_W-1:0] s_stride;
  pix_fmt_e            s_fmt;

  logic h_wrap, v_wrap, h_in, v_in, frame_end;
  logic [CNT_W-1:0] col;

  assign frame_end = h_wrap & v_wrap;

  always_ff @(posedge clk) begin
    if (!rst_n || frame_end) begin
      s_h_total <= cfg_h_total;
      s_v_total <= cfg_v_total;
      s_hsync   <= cfg_hsync_len;
      s_vsync   <= cfg_vsync_len;
      s_x_off   <= cfg_x_off;
      s_width   <= cfg_width;
      s_y_off   <= cfg_y_off;
      s_height  <= cfg_height;
      s_stride  <= cfg_stride;
      s_fmt     <= pix_fmt_e'(cfg_fmt);
    end
  end

  fbw_axis #(.CNT_W(CNT_W)) h_axis_i (
    .clk(clk), .rst_n(rst_n), .step(1'b1),
    .total(s_h_total), .sync_len(s_hsync),
    .win_off(s_x_off), .win_len(s_width),
    .cnt(h_cnt), .wrap(h_wrap), .sync(hsync), .in_win(h_in)
  );

  fbw_axis #(.CNT_W(CNT_W)) v_axis_i (
    .clk(clk), .rst_n(rst_n), .step(h_wrap),
    .total(s_v_total), .sync_len(s_vsync),
    .win_off(s_y_off), .win_len(s_height),
    .cnt(v_cnt), .wrap(v_wrap), .sync(vsync), .in_win(v_in)
  );

  assign win_active = h_in & v_in;
  assign fetch_req  = win_active;
  assign col        = h_cnt - s_x_off;

  fbw_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .STRIDE_W(STRIDE_W)) addr_i (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .line_end(h_wrap),
    .row_in_win(v_in), .active(win_active), .base_in(cfg_base),
    .stride(s_stride), .col(col), .fmt(s_fmt), .addr(fetch_addr)
  );

  assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> ($stable(s_h_total) && $stable(s_v_total) && $stable(s_x_off)
                    && $stable(s_width) && $stable(s_stride) && $stable(s_fmt)));

  assert_frame_end_origin_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (h_cnt == '0 && v_cnt == '0));

  assert_req_inside_raster_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> (h_cnt >= s_x_off && v_cnt >= s_y_off));

endmodule

// File: tb/fb_window_timing_tb_top.sv
module fb_window_timing_tb_top;

  typedef struct packed {
    int ht; int vt; int hs; int vs; int xo; int w; int yo; int h;
    int st; int base; int fmt;
  } cfg_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  cfg_t live, shd;
  int   mx, my;
  int   n_tests = 0, n_fail = 0;
  bit   done = 1'b0;

  logic [11:0] h_cnt, v_cnt;
  logic        hsync, vsync, win_active, fetch_req;
  logic [21:0] fetch_addr;

  fb_window_timing dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_h_total(live.ht[11:0]), .cfg_v_total(live.vt[11:0]),
    .cfg_hsync_len(live.hs[11:0]), .cfg_vsync_len(live.vs[11:0]),
    .cfg_x_off(live.xo[11:0]), .cfg_width(live.w[11:0]),
    .cfg_y_off(live.yo[11:0]), .cfg_height(live.h[11:0]),
    .cfg_stride(live.st[15:0]), .cfg_base(live.base[21:0]),
    .cfg_fmt(live.fmt[1:0]),
    .h_cnt(h_cnt), .v_cnt(v_cnt), .hsync(hsync), .vsync(vsync),
    .win_active(win_active), .fetch_req(fetch_req), .fetch_addr(fetch_addr)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at (%0d,%0d): actual=%0d expected=%0d", req, mx, my, act, exp);
    end
  endtask

  function automatic bit in_cfg(input cfg_t c, input int x, input int y);
    return x >= c.xo && x < c.xo + c.w && y >= c.yo && y < c.yo + c.h;
  endfunction

  function automatic int exp_addr(input cfg_t c, input int x, input int y);
    int col, p;
    col = x - c.xo;
    if (c.fmt == 0)      p = col;
    else if (c.fmt == 1) p = col / 2;
    else                 p = col * 2;
    return (c.base + (y - c.yo) * c.st + p) & 32'h003F_FFFF;
  endfunction

  task automatic compare();
    bit inw;
    inw = in_cfg(shd, mx, my);
    chk(int'(h_cnt) == mx, "R1 h_cnt", h_cnt, mx);
    chk(int'(v_cnt) == my, "R2 v_cnt", v_cnt, my);
    chk(hsync == (mx < shd.hs), "R3 hsync", hsync, mx < shd.hs);
    chk(vsync == (my < shd.vs), "R3 vsync", vsync, my < shd.vs);
    chk(win_active == inw, "R4 win_active", win_active, inw);
    chk(fetch_req == inw, "R5 fetch_req", fetch_req, inw);
    if (inw) chk(int'(fetch_addr) == exp_addr(shd, mx, my), "R6 fetch_addr",
                 fetch_addr, exp_addr(shd, mx, my));
    else     chk(fetch_addr == '0, "R5 idle addr", fetch_addr, 0);
  endtask

  // Compare, advance the model as the posedge will, then wait a cycle
  task automatic step();
    compare();
    if (mx == shd.ht - 1) begin
      mx = 0;
      if (my == shd.vt - 1) begin my = 0; shd = live; end
      else my++;
    end else mx++;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    mx = 0; my = 0; shd = live;
  endtask

  function automatic cfg_t small_cfg(input int fmt, input int st, input int base);
    cfg_t c;
    c.ht = 20; c.vt = 12; c.hs = 3; c.vs = 2;
    c.xo = 4; c.w = 10; c.yo = 2; c.h = 6;
    c.st = st; c.base = base; c.fmt = fmt;
    return c;
  endfunction

  task automatic t_reset_state();
    live = small_cfg(0, 64, 'h100);
    do_reset();
    chk(h_cnt == 0, "R1 reset h_cnt", h_cnt, 0);
    chk(v_cnt == 0, "R2 reset v_cnt", v_cnt, 0);
    chk(hsync == 1'b1 && vsync == 1'b1, "R3 reset syncs", {hsync, vsync}, 3);
    chk(win_active == 1'b0 && fetch_req == 1'b0, "R5 reset idle", fetch_req, 0);
  endtask

  task automatic t_byte_frames();
    live = small_cfg(0, 64, 'h100);
    do_reset();
    repeat (2 * 20 * 12 + 5) step();
  endtask

  task automatic t_nibble_wrap();
    live = small_cfg(1, 12, 'h3FFFF8);
    do_reset();
    repeat (2 * 20 * 12) step();
  endtask

  // R7: row pitch equals stride regardless of width*bpp
  task automatic t_stride(input int fmt, input int st);
    int a0, a1;
    a0 = -1; a1 = -1;
    live = small_cfg(fmt, st, 'h2000);
    do_reset();
    repeat (20 * 12) begin
      if (mx == live.xo && my == live.yo)     a0 = int'(fetch_addr);
      if (mx == live.xo && my == live.yo + 1) a1 = int'(fetch_addr);
      step();
    end
    chk(a1 - a0 == st, "R7 row pitch", a1 - a0, st);
  endtask

  // R8: mid-frame change is deferred to the next frame
  task automatic t_midframe();
    cfg_t old_c;
    bit crossed;
    live = small_cfg(0, 32, 'h400);
    do_reset();
    repeat (45) step();
    old_c = live;
    live.xo = 9; live.w = 8; live.yo = 4; live.h = 3; live.base = 'h7000;
    live.st = 50; live.hs = 5;
    crossed = 1'b0;
    repeat (2 * 20 * 12) begin
      if (mx == 0 && my == 0) crossed = 1'b1;
      chk(win_active == in_cfg(crossed ? live : old_c, mx, my), "R8 deferred window",
          win_active, in_cfg(crossed ? live : old_c, mx, my));
      step();
    end
    chk(crossed, "R8 boundary reached", crossed, 1);
  endtask

  task automatic t_large(input int ht, input int xo, input int w);
    live.ht = ht; live.vt = 488; live.hs = 32; live.vs = 8;
    live.xo = xo; live.w = w; live.yo = 8; live.h = 480;
    live.st = 2048; live.base = 'h1000; live.fmt = 3;
    do_reset();
    repeat (ht * 12) step();
  endtask

  initial begin
    live = small_cfg(0, 64, 'h100);
    shd = live; mx = 0; my = 0;
    t_reset_state();
    t_byte_frames();
    t_nibble_wrap();
    t_stride(2, 40);
    t_stride(3, 6);
    t_midframe();
    t_large(950, 96, 854);
    t_large(1056, 202, 854);
    t_large(950, 203, 640);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule